// File: doc/BRIEF.md
# 10BASE-T Jabber Lockout and SQE Heartbeat Monitor

This block watches the transmit-enable signal that a MAC drives toward a 10 Mb/s copper transceiver. It produces two effects on the collision signal that goes back to the MAC. First, shortly after every frame ends, it emits a brief heartbeat pulse, the SQE test, which tells the MAC that its collision path works. Second, it guards the medium against a stuck transmitter. When transmit enable stays asserted far longer than any legal frame, it inhibits the transmitter and holds collision high. It lifts the inhibit only after transmit enable has stayed quiet for a much longer interval.

The block runs from a free-running reference clock. Every duration is a parameter given in clock ticks: the trip time, the quiet time, the heartbeat delay and the heartbeat width. At a 25 MHz clock the defaults correspond to 20 ms to trip, 250 ms of quiet to recover, and a heartbeat of about 1 us. The block acts only while the 10 Mb/s mode flag is high. Dropping that flag clears all of its state. The collision output is one contribution, to be ORed with real collision detection elsewhere.

Top module: `jabber_sqe_monitor`

## Requirements
- R1: While `rst` is sampled high, and on the clock after it is released, `tx_inhibit` and `col_out` are both low.
- R2: In 10 Mb/s mode and outside lockout, a frame end is the first clock edge at which `tx_en` is sampled low after having been sampled high on the previous edge. Counting that edge as edge 0, `col_out` rises after edge SQE_DELAY and stays high for exactly SQE_LEN clocks.
- R3: Outside lockout, `tx_inhibit` rises after the edge at which `tx_en` has been sampled high on TRIP_TICKS consecutive edges. A run of TRIP_TICKS-1 high samples does not trip.
- R4: While `tx_inhibit` is high, `col_out` is high.
- R5: In lockout, `tx_inhibit` and `col_out` fall after the edge at which `tx_en` has been sampled low on QUIET_TICKS consecutive edges. QUIET_TICKS-1 low samples are not enough.
- R6: A single high sample of `tx_en` during lockout restarts the quiet count from zero.
- R7: The frame that trips the lockout gets no heartbeat, no frame end during lockout gets one, and a heartbeat still pending when the trip occurs is cancelled.
- R8: With `mode_10m` sampled low, both outputs are low after that edge, the trip, quiet and heartbeat state is cleared, and frames produce neither a heartbeat nor a trip.
- R9: A new frame end while a heartbeat is pending or in progress restarts the heartbeat timing from that new edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_10m | input | 1 | High while the link runs at 10 Mb/s |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_inhibit | output | 1 | High while the transmitter is locked out |
| col_out | output | 1 | Collision contribution: heartbeat pulse or lockout hold |

## Verification
The assertions assume that `tx_en` and `mode_10m` are synchronous to `clk` and settle between edges. They also assume that `rst` is held for at least one edge before any check is meant to apply. The stimulus changes every input at the falling clock edge, so each input is stable when it is sampled. Random frame and gap lengths are drawn on both sides of the trip threshold, and some gaps are long enough to cross the quiet threshold. Reset is only applied at the start of the run.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_phase_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/jsm_trip_timer.sv
module jsm_trip_timer #(
  parameter int unsigned TRIP_TICKS = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tx_en,
  input  logic locked,
  output logic trip
);
  import jsm_pkg::*;

  localparam int unsigned CW = cnt_width(TRIP_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TRIP_TICKS - 1);

  logic [CW-1:0] hi_cnt;

  assign trip = run && !locked && tx_en && (hi_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || locked || !tx_en || trip) begin
      hi_cnt <= '0;
    end else begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_HI_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= LAST); // R3

  AST_TRIP_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt != '0) |-> $past(tx_en)); // R3

endmodule

// File: rtl/jsm_quiet_timer.sv
module jsm_quiet_timer #(
  parameter int unsigned QUIET_TICKS = 6250000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tx_en,
  input  logic locked,
  output logic release_lock
);
  import jsm_pkg::*;

  localparam int unsigned CW = cnt_width(QUIET_TICKS);
  localparam logic [CW-1:0] LAST = CW'(QUIET_TICKS - 1);

  logic [CW-1:0] lo_cnt;

  assign release_lock = run && locked && !tx_en && (lo_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || !locked || tx_en || release_lock) begin
      lo_cnt <= '0;
    end else begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  AST_QUIET_RESTART: assert property (@(posedge clk) disable iff (rst)
    (run && locked && tx_en) |=> (lo_cnt == '0)); // R6

  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst)
    lo_cnt <= LAST); // R5

endmodule

// File: rtl/jsm_sqe_gen.sv
module jsm_sqe_gen #(
  parameter int unsigned SQE_DELAY = 12,
  parameter int unsigned SQE_LEN   = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  input  logic abort,
  output logic pulse
);
  import jsm_pkg::*;

  localparam int unsigned CNT_MAX = (SQE_DELAY > SQE_LEN) ? SQE_DELAY : SQE_LEN;
  localparam int unsigned CW = cnt_width(CNT_MAX);
  localparam logic [CW-1:0] LEN_LAST = CW'(SQE_LEN - 1);

  sqe_phase_t    phase;
  logic [CW-1:0] cnt;
  sqe_phase_t    entry_phase;
  logic [CW-1:0] entry_cnt;

  generate
    if (SQE_DELAY == 0) begin : g_nodelay
      assign entry_phase = SQE_PULSE;
      assign entry_cnt   = LEN_LAST;
    end else begin : g_delay
      assign entry_phase = SQE_WAIT;
      assign entry_cnt   = CW'(SQE_DELAY - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run || abort) begin
      phase <= SQE_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase <= entry_phase;
      cnt   <= entry_cnt;
    end else begin
      case (phase)
        SQE_WAIT: begin
          if (cnt == '0) begin
            phase <= SQE_PULSE;
            cnt   <= LEN_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQE_PULSE: begin
          if (cnt == '0) begin
            phase <= SQE_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          phase <= SQE_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign pulse = (phase == SQE_PULSE);

  AST_NO_SQE_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
    abort |=> !pulse); // R7

  AST_SQE_OFF_OUTSIDE_10M: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pulse); // R8

endmodule

// File: rtl/jabber_sqe_monitor.sv
module jabber_sqe_monitor #(
  parameter int unsigned TRIP_TICKS  = 500000,
  parameter int unsigned QUIET_TICKS = 6250000,
  parameter int unsigned SQE_DELAY   = 12,
  parameter int unsigned SQE_LEN     = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_10m,
  input  logic tx_en,
  output logic tx_inhibit,
  output logic col_out
);

  logic prev_en;
  logic locked;
  logic trip;
  logic release_lock;
  logic frame_end;
  logic sqe_pulse;

  initial begin
    if (TRIP_TICKS < 1 || QUIET_TICKS < 1 || SQE_LEN < 1) begin
      $error("jabber_sqe_monitor: tick parameters must be at least 1");
    end
  end

  jsm_trip_timer #(.TRIP_TICKS(TRIP_TICKS)) i_trip (
    .clk    (clk),
    .rst    (rst),
    .run    (mode_10m),
    .tx_en  (tx_en),
    .locked (locked),
    .trip   (trip)
  );

  jsm_quiet_timer #(.QUIET_TICKS(QUIET_TICKS)) i_quiet (
    .clk          (clk),
    .rst          (rst),
    .run          (mode_10m),
    .tx_en        (tx_en),
    .locked       (locked),
    .release_lock (release_lock)
  );

  assign frame_end = mode_10m && prev_en && !tx_en && !locked;

  jsm_sqe_gen #(.SQE_DELAY(SQE_DELAY), .SQE_LEN(SQE_LEN)) i_sqe (
    .clk   (clk),
    .rst   (rst),
    .run   (mode_10m),
    .start (frame_end),
    .abort (locked || trip),
    .pulse (sqe_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst || !mode_10m) begin
      prev_en <= 1'b0;
      locked  <= 1'b0;
    end else begin
      prev_en <= tx_en;
      if (trip) begin
        locked <= 1'b1;
      end else if (release_lock) begin
        locked <= 1'b0;
      end
    end
  end

  assign tx_inhibit = locked;
  assign col_out    = locked | sqe_pulse;

  AST_INHIBIT_ONLY_10M: assert property (@(posedge clk) disable iff (rst)
    !mode_10m |=> (!tx_inhibit && !col_out)); // R8

  AST_TRIP_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_inhibit) |-> $past(tx_en)); // R3

  AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_inhibit) && $past(mode_10m)) |-> !$past(tx_en)); // R5

  AST_COL_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
    (tx_inhibit && mode_10m) |=> (col_out || !tx_inhibit)); // R4

endmodule

// File: tb/test_jabber_sqe_monitor.sv
module test_jabber_sqe_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int TRIP  = 20;
  localparam int QUIET = 50;
  localparam int DLY   = 3;
  localparam int LEN   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_10m = 1'b0;
  logic tx_en = 1'b0;
  logic tx_inhibit;
  logic col_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_hi = 0, m_lo = 0, m_cnt = 0, m_ph = 0;
  bit m_lock = 0, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jabber_sqe_monitor #(
    .TRIP_TICKS(TRIP), .QUIET_TICKS(QUIET), .SQE_DELAY(DLY), .SQE_LEN(LEN)
  ) i_jabber_sqe_monitor (
    .clk(clk), .rst(rst), .mode_10m(mode_10m), .tx_en(tx_en),
    .tx_inhibit(tx_inhibit), .col_out(col_out)
  );

  // Expected outputs derived from requirements R2..R9
  function automatic bit exp_inhibit();
    return m_lock;
  endfunction

  function automatic bit exp_col();
    return m_lock || (m_ph == 2);
  endfunction

  task automatic model_edge(input bit r, input bit m, input bit e);
    bit fall;
    bit tripped;
    if (r || !m) begin
      m_hi = 0; m_lo = 0; m_ph = 0; m_cnt = 0; m_lock = 0; m_prev = 0;
      return;
    end
    tripped = 0;
    if (!m_lock) begin
      fall = m_prev && !e;
      if (e) begin
        if (m_hi + 1 >= TRIP) begin m_lock = 1; m_hi = 0; tripped = 1; end
        else m_hi++;
      end else m_hi = 0;
      if (tripped) begin m_ph = 0; end
      else if (fall) begin m_ph = 1; m_cnt = DLY - 1; end
      else if (m_ph == 1) begin
        if (m_cnt == 0) begin m_ph = 2; m_cnt = LEN - 1; end else m_cnt--;
      end else if (m_ph == 2) begin
        if (m_cnt == 0) m_ph = 0; else m_cnt--;
      end
    end else begin
      m_ph = 0;
      if (e) m_lo = 0;
      else if (m_lo + 1 >= QUIET) begin m_lock = 0; m_lo = 0; end
      else m_lo++;
    end
    m_prev = e;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (tx_inhibit !== exp_inhibit()) begin
      fails++;
      $display("FAIL %s tx_inhibit actual %0b expected %0b at %0t", tag, tx_inhibit, exp_inhibit(), $time);
    end
    checks++;
    if (col_out !== exp_col()) begin
      fails++;
      $display("FAIL %s col_out actual %0b expected %0b at %0t", tag, col_out, exp_col(), $time);
    end
  endtask

  task automatic step(input bit m, input bit e, input string tag);
    mode_10m = m;
    tx_en = e;
    @(posedge clk);
    model_edge(rst, m, e);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_level(input bit m, input bit e, input int n, input string tag);
    for (int i = 0; i < n; i++) step(m, e, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    @(negedge clk);
    // R1: reset state
    rst = 1'b1;
    run_level(1'b1, 1'b1, 3, "R1 in reset");
    rst = 1'b0;
    step(1'b1, 1'b0, "R1 after release");

    // R2: heartbeat after a short frame
    run_level(1'b1, 1'b1, 8, "R2 frame");
    run_level(1'b1, 1'b0, 12, "R2 heartbeat");

    // R3: one tick short of trip, no lockout
    run_level(1'b1, 1'b1, TRIP - 1, "R3 below trip");
    run_level(1'b1, 1'b0, 10, "R3 below trip tail");

    // R3/R4/R7: trip, hold, no heartbeat for the tripping frame
    run_level(1'b1, 1'b1, TRIP, "R3 trip");
    run_level(1'b1, 1'b1, 5, "R4 col held");
    run_level(1'b1, 1'b0, QUIET - 1, "R7 no heartbeat in lockout");
    step(1'b1, 1'b0, "R5 release");
    run_level(1'b1, 1'b0, 8, "R5 after release");

    // R6: quiet restart
    run_level(1'b1, 1'b1, TRIP + 5, "R6 trip");
    run_level(1'b1, 1'b0, 30, "R6 quiet part");
    run_level(1'b1, 1'b1, 2, "R6 blip");
    run_level(1'b1, 1'b0, QUIET - 1, "R6 restarted count");
    run_level(1'b1, 1'b0, 5, "R6 release");

    // R7: pending heartbeat cancelled by trip
    run_level(1'b1, 1'b1, 4, "R7 frame");
    step(1'b1, 1'b0, "R7 frame end");
    run_level(1'b1, 1'b1, TRIP, "R7 trip cancels");
    run_level(1'b1, 1'b0, QUIET + 3, "R7 recover");

    // R9: heartbeat restart on a new frame end
    run_level(1'b1, 1'b1, 4, "R9 frame a");
    run_level(1'b1, 1'b0, 2, "R9 gap");
    run_level(1'b1, 1'b1, 3, "R9 frame b");
    run_level(1'b1, 1'b0, 12, "R9 restarted heartbeat");

    // R8: mode low
    run_level(1'b0, 1'b1, TRIP + 10, "R8 long frame outside 10M");
    run_level(1'b0, 1'b0, 10, "R8 no heartbeat outside 10M");
    run_level(1'b1, 1'b1, TRIP, "R8 trip");
    run_level(1'b0, 1'b0, 2, "R8 clear lockout");
    run_level(1'b1, 1'b0, 10, "R8 stays clear");

    // random frames across both thresholds (R2 R3 R5)
    for (int f = 0; f < 60; f++) begin
      int len = $urandom_range(1, TRIP + 8);
      int gap = $urandom_range(1, QUIET + 20);
      bit md = ($urandom_range(0, 9) != 0);
      run_level(md, 1'b1, len, "R3 random frame");
      run_level(md, 1'b0, gap, "R2 random gap");
    end

    finish_run();
  end

endmodule